// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block sits between instruction decode and issue. It takes one decoded three-operand instruction and expands it into a strictly ordered series of per-element operations, from element 0 up to the vector length minus one. Each of the destination and the two sources carries a base register number and a flag that marks it as scalar or vector. A vector operand walks forward one register per element. A scalar operand stays on its base register. A single loop covers all eight scalar/vector mixes.

For each enabled element the sequencer presents the two source addresses to an attached ALU port. It waits for the port's ready, takes the result back in the same cycle and writes it to the destination. A predicate mask can switch single elements off. A switched-off element still moves every vector offset forward, and in zeroing mode it writes zero to its destination. A scalar destination ends the loop after its first real write. An optional fail-first mode tests one condition flag of each result (negative, positive or zero) against an expected value. At the first mismatch it cuts the vector length down to that element's index and drops that result. While the loop runs, `busy` holds the program counter. A one-cycle `done` pulse and the final vector length mark the end of the loop.

Top module: `elem_loop_seq`

## Requirements
- R1: After an accepted `start` with nonzero `vl_in`, `busy` is high from the next cycle until the cycle after the last element. Elements are handled one per cycle at most, in increasing index order from 0.
- R2: The address of a vector-flagged operand is its base plus the element index, modulo 2^REG_AW. A scalar-flagged operand always addresses its base register.
- R3: With a scalar destination, the loop ends in the cycle of the first element whose ALU result is written.
- R4: When predication is enabled and mask bit i (bit 0 = element 0) is 0, element i makes no ALU request and writes no result. It takes exactly one cycle, and all vector offsets still advance.
- R5: When `pred_en` is 0, every element is treated as enabled, whatever `pred_mask` holds.
- R6: When `zero_en` is 1, a masked-out element writes the value 0 to its destination address in its cycle.
- R7: In fail-first mode, the result is read as a signed value. `ff_sel` = 0 selects negative, 1 selects positive, and 2 or 3 select zero. For an enabled element whose selected flag differs from `ff_expect`: no write happens, `vl_out` becomes that element's index, `vl_trunc` is set and the loop ends. Masked-out elements are not tested.
- R8: A `start` with `vl_in` = 0 never raises `busy` and causes no write. It gives `done` in the next cycle with `vl_out` = 0 and `vl_trunc` = 0.
- R9: An enabled element is held while `alu_ready` is 0: its index and addresses do not change until a cycle in which `alu_ready` is 1.
- R10: `done` is a one-cycle pulse in the cycle after the loop's last element. `vl_out` equals `vl_in` unless truncated, `vl_trunc` is 0 unless truncated, and both hold until the next accepted start. Both reset to 0.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid; sampled only while not busy |
| vl_in | input | VLW | Vector length, 0 to VL_MAX |
| rt_base | input | REG_AW | Destination base register |
| ra_base | input | REG_AW | First source base register |
| rb_base | input | REG_AW | Second source base register |
| rt_vec | input | 1 | Destination is a vector |
| ra_vec | input | 1 | First source is a vector |
| rb_vec | input | 1 | Second source is a vector |
| pred_en | input | 1 | Use the predicate mask |
| pred_mask | input | VL_MAX | Predicate, bit i enables element i |
| zero_en | input | 1 | Write zero for masked-out elements |
| ff_en | input | 1 | Enable fail-first testing |
| ff_sel | input | 2 | Condition flag: 0 negative, 1 positive, 2/3 zero |
| ff_expect | input | 1 | Expected value of the selected flag |
| busy | output | 1 | Loop running; hold the program counter |
| alu_valid | output | 1 | Element request to the ALU port |
| alu_ready | input | 1 | ALU port accepts the request and returns its result |
| ra_addr | output | REG_AW | First source read address |
| rb_addr | output | REG_AW | Second source read address |
| alu_result | input | DATA_W | ALU result, valid while alu_valid and alu_ready |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | REG_AW | Destination write address |
| wr_data | output | DATA_W | Write data (result or zero) |
| done | output | 1 | Loop-finished pulse |
| vl_out | output | VLW | Final vector length |
| vl_trunc | output | 1 | Fail-first truncation happened |

## Verification
The assertions check these properties on every cycle: the index steps by one after each accepted non-final element, an element stalled on `alu_ready` keeps its index, a real write to a scalar destination ends the loop, a write made without an ALU request carries zero, a truncated length is shorter than the requested one, `done` lasts one cycle, and a `start` during a run leaves the latched length alone. Some properties depend on whole scenarios, and only the bench's cycle-by-cycle model shows them. These are the exact address sequences with wraparound, the element at which a scalar destination stops after leading masked bits, the sequence of zero writes, the index a fail-first condition truncates to, and how the run behaves with zero length.

// File: rtl/elem_loop_seq.sv
module elem_loop_seq #(
  parameter int VL_MAX = 64,
  parameter int REG_AW = 7,
  parameter int DATA_W = 64,
  localparam int VLW = $clog2(VL_MAX + 1),
  localparam int IW  = (VL_MAX > 1) ? $clog2(VL_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VLW-1:0]    vl_in,
  input  logic [REG_AW-1:0] rt_base,
  input  logic [REG_AW-1:0] ra_base,
  input  logic [REG_AW-1:0] rb_base,
  input  logic              rt_vec,
  input  logic              ra_vec,
  input  logic              rb_vec,
  input  logic              pred_en,
  input  logic [VL_MAX-1:0] pred_mask,
  input  logic              zero_en,
  input  logic              ff_en,
  input  logic [1:0]        ff_sel,
  input  logic              ff_expect,
  output logic              busy,
  output logic              alu_valid,
  input  logic              alu_ready,
  output logic [REG_AW-1:0] ra_addr,
  output logic [REG_AW-1:0] rb_addr,
  input  logic [DATA_W-1:0] alu_result,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic [VLW-1:0]    vl_out,
  output logic              vl_trunc
);

  logic              run;
  logic [VLW-1:0]    idx, vl_q;
  logic [REG_AW-1:0] rt_q, ra_q, rb_q;
  logic              rtv_q, rav_q, rbv_q, zero_q, ff_q, exp_q;
  logic [1:0]        sel_q;
  logic [VL_MAX-1:0] pred_q;

  logic [REG_AW-1:0] step;
  logic              pbit, res_neg, res_zero, cond, fail, accept, last;

  assign step     = REG_AW'(idx);
  assign pbit     = pred_q[idx[IW-1:0]];
  assign res_neg  = alu_result[DATA_W-1];
  assign res_zero = (alu_result == '0);

  always_comb begin
    case (sel_q)
      2'd0:    cond = res_neg;
      2'd1:    cond = !res_neg && !res_zero;
      default: cond = res_zero;
    endcase
  end

  assign busy      = run;
  assign alu_valid = run && pbit;
  assign ra_addr   = ra_q + (rav_q ? step : '0);
  assign rb_addr   = rb_q + (rbv_q ? step : '0);
  assign wr_addr   = rt_q + (rtv_q ? step : '0);
  assign fail      = run && pbit && ff_q && (cond != exp_q);
  assign accept    = run && (pbit ? alu_ready : 1'b1);
  assign last      = (idx == vl_q - VLW'(1)) || (pbit && !rtv_q) || fail;
  assign wr_en     = run && (pbit ? (alu_ready && !fail) : zero_q);
  assign wr_data   = pbit ? alu_result : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; idx <= '0; vl_q <= '0;
      rt_q <= '0; ra_q <= '0; rb_q <= '0;
      rtv_q <= 1'b0; rav_q <= 1'b0; rbv_q <= 1'b0;
      zero_q <= 1'b0; ff_q <= 1'b0; exp_q <= 1'b0; sel_q <= '0;
      pred_q <= '0; done <= 1'b0; vl_out <= '0; vl_trunc <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          vl_q <= vl_in; rt_q <= rt_base; ra_q <= ra_base; rb_q <= rb_base;
          rtv_q <= rt_vec; rav_q <= ra_vec; rbv_q <= rb_vec;
          pred_q <= pred_en ? pred_mask : '1;
          zero_q <= zero_en; ff_q <= ff_en; sel_q <= ff_sel; exp_q <= ff_expect;
          vl_out <= vl_in; vl_trunc <= 1'b0;
          idx <= '0;
          run <= (vl_in != '0);
          done <= (vl_in == '0);
        end
      end else if (accept) begin
        if (fail) begin
          vl_out <= idx; vl_trunc <= 1'b1;
        end
        if (last) begin
          run <= 1'b0; done <= 1'b1;
        end else begin
          idx <= idx + VLW'(1);
        end
      end
    end
  end

  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    run && accept && !last |=> run && idx == $past(idx) + VLW'(1)); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid && !alu_ready |=> run && $stable(idx) && $stable(ra_addr) && $stable(rb_addr)); // R9
  AST_SCALAR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && alu_valid && !rtv_q |=> !run); // R3
  AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !alu_valid |-> wr_data == '0 && zero_q); // R6
  AST_TRUNC_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    done && vl_trunc |-> vl_out < vl_q); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    run && start |=> $stable(vl_q) && $stable(rt_q)); // R11

endmodule

// File: tb/elem_loop_seq_tb_top.sv
module elem_loop_seq_tb_top;
  localparam int VL_MAX = 64, REG_AW = 7, DATA_W = 64, VLW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [VLW-1:0] vl_in = '0;
  logic [REG_AW-1:0] rt_base = '0, ra_base = '0, rb_base = '0;
  logic rt_vec = 1'b0, ra_vec = 1'b0, rb_vec = 1'b0;
  logic pred_en = 1'b0, zero_en = 1'b0, ff_en = 1'b0, ff_expect = 1'b0;
  logic [VL_MAX-1:0] pred_mask = '0;
  logic [1:0] ff_sel = '0;
  logic alu_ready = 1'b0;
  logic busy, alu_valid, wr_en, done, vl_trunc;
  logic [REG_AW-1:0] ra_addr, rb_addr, wr_addr;
  logic [DATA_W-1:0] alu_result, wr_data;
  logic [VLW-1:0] vl_out;

  always #10 clk = ~clk;

  assign alu_result = 64'(ra_addr) - 64'(rb_addr);

  elem_loop_seq #(.VL_MAX(VL_MAX), .REG_AW(REG_AW), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
    .rt_base(rt_base), .ra_base(ra_base), .rb_base(rb_base),
    .rt_vec(rt_vec), .ra_vec(ra_vec), .rb_vec(rb_vec),
    .pred_en(pred_en), .pred_mask(pred_mask), .zero_en(zero_en),
    .ff_en(ff_en), .ff_sel(ff_sel), .ff_expect(ff_expect),
    .busy(busy), .alu_valid(alu_valid), .alu_ready(alu_ready),
    .ra_addr(ra_addr), .rb_addr(rb_addr), .alu_result(alu_result),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .vl_out(vl_out), .vl_trunc(vl_trunc));

  int checks = 0, fails = 0, cycles = 0;
  string scen = "R10";

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  bit m_run = 0, m_done = 0, m_tr = 0;
  int m_i = 0, m_vl = 0, m_vlo = 0, m_rt = 0, m_ra = 0, m_rb = 0, m_sel = 0;
  bit m_rtv, m_rav, m_rbv, m_z, m_ff, m_exp;
  bit [VL_MAX-1:0] m_mask;

  always @(negedge clk) if (rst_n) begin
    bit p, ev, ew, acc, lst, fl, c, nd;
    int ea, eb, et;
    longint res, ewd;
    ev = 0; ew = 0; acc = 0; lst = 0; fl = 0; ewd = 0; ea = 0; eb = 0; et = 0;
    if (m_run) begin
      p  = m_mask[m_i];
      ea = (m_ra + (m_rav ? m_i : 0)) % 128;
      eb = (m_rb + (m_rbv ? m_i : 0)) % 128;
      et = (m_rt + (m_rtv ? m_i : 0)) % 128;
      if (p) begin
        ev  = 1;
        res = longint'(ea) - longint'(eb);
        c   = (m_sel == 0) ? (res < 0) : (m_sel == 1) ? (res > 0) : (res == 0);
        fl  = m_ff && (c != m_exp);
        acc = alu_ready;
        ew  = acc && !fl;
        ewd = res;
      end else begin
        acc = 1; ew = m_z; ewd = 0;
      end
      lst = (m_i == m_vl - 1) || (p && !m_rtv) || fl;
    end
    check({"R1/", scen}, "busy", busy, m_run);
    check({"R4/", scen}, "alu_valid", alu_valid, ev);
    check({"R3/", scen}, "wr_en", wr_en, ew);
    check({"R10/", scen}, "done", done, m_done);
    check({"R10/", scen}, "vl_out", vl_out, m_vlo);
    check({"R7/", scen}, "vl_trunc", vl_trunc, m_tr);
    if (ev) begin
      check({"R2/", scen}, "ra_addr", ra_addr, ea);
      check({"R2/", scen}, "rb_addr", rb_addr, eb);
    end
    if (ew) begin
      check({"R2/", scen}, "wr_addr", wr_addr, et);
      check({"R6/", scen}, "wr_data", longint'(wr_data), ewd);
    end
    nd = 0;
    if (m_run) begin
      if (acc) begin
        if (fl) begin m_vlo = m_i; m_tr = 1; end
        if (lst) begin m_run = 0; nd = 1; end else m_i++;
      end
    end else if (start) begin
      m_vl = vl_in; m_rt = rt_base; m_ra = ra_base; m_rb = rb_base;
      m_rtv = rt_vec; m_rav = ra_vec; m_rbv = rb_vec;
      m_mask = pred_en ? pred_mask : '1;
      m_z = zero_en; m_ff = ff_en; m_sel = ff_sel; m_exp = ff_expect;
      m_vlo = vl_in; m_tr = 0; m_i = 0;
      m_run = (vl_in != 0); nd = (vl_in == 0);
    end
    m_done = nd;
  end

  logic [7:0] lfsr = 8'h5a;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    alu_ready = lfsr[0] | lfsr[2];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic issue(string tag, int vl, int rt, int ra, int rb, bit tv, bit av, bit bv,
                       bit pe, logic [VL_MAX-1:0] mask, bit z, bit ff, int sel, bit ex, bit poke);
    scen = tag;
    @(posedge clk); #2;
    vl_in = VLW'(vl); rt_base = REG_AW'(rt); ra_base = REG_AW'(ra); rb_base = REG_AW'(rb);
    rt_vec = tv; ra_vec = av; rb_vec = bv; pred_en = pe; pred_mask = mask;
    zero_en = z; ff_en = ff; ff_sel = 2'(sel); ff_expect = ex; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
    if (poke) begin
      @(posedge clk); #2;
      vl_in = 3; rt_base = 99; start = 1'b1;
      @(posedge clk); #2; start = 1'b0;
    end
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (done) break;
    end
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // reset state is compared by the model from the first cycle: R10
    issue("R1", 5, 20, 0, 40, 1, 1, 1, 0, '0, 0, 0, 0, 0, 0);
    issue("R3", 8, 5, 10, 30, 0, 1, 1, 0, '0, 0, 0, 0, 0, 0);
    issue("R4", 8, 50, 60, 70, 1, 1, 1, 1, 64'b1010_0110, 0, 0, 0, 0, 0);
    issue("R3", 6, 5, 10, 30, 0, 1, 1, 1, 64'b1000, 0, 0, 0, 0, 0);
    issue("R6", 4, 8, 1, 2, 1, 1, 1, 1, 64'b0101, 1, 0, 0, 0, 0);
    issue("R6", 5, 9, 3, 4, 0, 1, 0, 1, 64'b0100, 1, 0, 0, 0, 0);
    issue("R5", 4, 30, 7, 2, 1, 0, 0, 0, 64'h0, 0, 0, 0, 0, 0);
    issue("R2", 4, 126, 125, 127, 1, 1, 1, 0, '0, 0, 0, 0, 0, 0);
    issue("R8", 0, 1, 2, 3, 1, 1, 1, 0, '0, 0, 0, 0, 0, 0);
    issue("R7", 8, 40, 10, 13, 1, 1, 0, 0, '0, 0, 1, 2, 0, 0);
    issue("R7", 8, 40, 10, 13, 1, 1, 0, 1, 64'hF7, 0, 1, 2, 0, 0);
    issue("R7", 8, 40, 0, 4, 1, 1, 0, 0, '0, 0, 1, 0, 1, 0);
    issue("R7", 8, 40, 0, 2, 1, 1, 0, 0, '0, 0, 1, 1, 0, 0);
    issue("R9", 64, 0, 64, 32, 1, 1, 1, 1, 64'hA5C3_0FF0_5A3C_F00F, 0, 0, 0, 0, 0);
    issue("R11", 10, 60, 5, 6, 1, 1, 1, 0, '0, 0, 0, 0, 0, 1);
    issue("R8", 0, 1, 2, 3, 1, 1, 1, 0, '0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule